// File: doc/BRIEF.md
# UART FIFO Interrupt Register Bank

This block is the software-facing side of a UART. A processor reaches it over a plain 32-bit register bus (address, write enable, write data, read strobe, combinational read data). Behind the registers sit two 128-entry byte FIFOs. Writing the transmit data register queues a byte for the serial engine. Reading the receive data register takes the oldest received byte. The serial framing engine is a separate block. It drains the transmit FIFO and fills the receive FIFO through dedicated pop and push ports, and it reports line break and receive idle-timeout as single-cycle pulses.

Interrupts are level conditions derived from the FIFO fill counts and two programmable watermarks, plus two sticky event flags. Each source has an enable bit and a write-one-to-clear bit. The clear bit matters only for the sticky flags. A masked status register shows which enabled sources are active, and a single interrupt line is their OR. The bank also holds the line-control, divider and control words that the framing engine consumes, and it drives them out as plain configuration outputs.

Top module: `uart_irq_regbank`

## Requirements
- R1: After reset both FIFO counts are 0, the enable register reads 0, control2 reads 0x00004040 (both watermarks 0x40), control1, line control and divider read 0, and irq is low.
- R2: A write to offset 0x00 appends wdata[7:0] to the transmit FIFO. The engine receives bytes on tx_data in write order, advancing one per tx_pop cycle while tx_avail is high. A write to a full transmit FIFO (128 entries) is discarded.
- R3: A read strobe at offset 0x04 returns the oldest received byte in rdata[7:0] in the same cycle and removes it. With the receive FIFO empty the read returns 0 and the count stays 0.
- R4: Offset 0x0C reads the receive count in bits 7:0 and the transmit count in bits 15:8. Both counts are updated one clock after the push or pop.
- R5: Offset 0x20 holds the receive watermark in bits 6:0 and the transmit watermark in bits 14:8. The receive-full source (bit 0) is active while receive count >= receive watermark. The transmit-empty source (bit 1) is active while transmit count <= transmit watermark.
- R6: A pulse on brk_evt sets the break flag (bit 7), and a pulse on tmo_evt sets the timeout flag (bit 13). Each flag stays set until a write to offset 0x14 with a 1 in its bit. Writing 0 there has no effect. A pulse in the same cycle as the clearing write leaves the flag set.
- R7: Offset 0x10 is the enable register. It keeps only bits 0, 1, 7 and 13. Offset 0x2C reads the active sources ANDed with the enables, in the same bit positions, with every other bit 0.
- R8: irq is high exactly when the masked status at 0x2C is nonzero.
- R9: Offset 0x1C is a 32-bit control word. Its bit 15 drives dma_en and its bit 14 drives loop_en.
- R10: Offset 0x18 keeps 8 bits and drives line_ctl. Offset 0x24 keeps 16 bits and offset 0x28 keeps 5 bits. baud_div is {0x28 value, 0x24 value}.
- R11: Offset 0x08 reads bit 0 = receive FIFO not empty, bit 7 = break flag, bit 15 = transmit FIFO not full, and all other bits 0.
- R12: An rx_push while the receive FIFO holds 128 bytes is discarded. The stored bytes and the count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops receive data at 0x04) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tx_pop | input | 1 | Engine takes the transmit head byte |
| tx_data | output | DW | Transmit FIFO head byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | DW | Received byte |
| brk_evt | input | 1 | Break detected pulse |
| tmo_evt | input | 1 | Receive timeout pulse |
| dma_en | output | 1 | Control word bit 15 |
| loop_en | output | 1 | Control word bit 14 |
| line_ctl | output | 8 | Line control value |
| baud_div | output | 21 | Baud divider |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for several conditions. Transmit occupancy never passes 128. A write into a full transmit FIFO and a read from an empty receive FIFO leave the count where it was. An event pulse always leaves its flag set on the next cycle, and a flag drops only after a clearing write. irq never rises while all enables are zero. Other behaviour needs the bench's scenarios and reference model: byte ordering through both FIFOs, exact watermark boundaries, the masked status value, the status field positions and the configuration outputs.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
  // Register byte offsets (software decodes these)
  localparam logic [7:0] OFS_TXD  = 8'h00;
  localparam logic [7:0] OFS_RXD  = 8'h04;
  localparam logic [7:0] OFS_LST  = 8'h08;
  localparam logic [7:0] OFS_FST  = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h10;
  localparam logic [7:0] OFS_ICLR = 8'h14;
  localparam logic [7:0] OFS_LCR  = 8'h18;
  localparam logic [7:0] OFS_CTL1 = 8'h1C;
  localparam logic [7:0] OFS_CTL2 = 8'h20;
  localparam logic [7:0] OFS_DIVL = 8'h24;
  localparam logic [7:0] OFS_DIVH = 8'h28;
  localparam logic [7:0] OFS_IMS  = 8'h2C;

  // Interrupt bit positions shared by enable, clear and masked status
  localparam int BIT_RXF = 0;
  localparam int BIT_TXE = 1;
  localparam int BIT_BRK = 7;
  localparam int BIT_TMO = 13;

  typedef struct packed {
    logic tmo;
    logic brk;
    logic txe;
    logic rxf;
  } isrc_t;

  function automatic logic [31:0] isrc_to_word(isrc_t s);
    logic [31:0] w;
    w = '0;
    w[BIT_RXF] = s.rxf;
    w[BIT_TXE] = s.txe;
    w[BIT_BRK] = s.brk;
    w[BIT_TMO] = s.tmo;
    return w;
  endfunction

  function automatic isrc_t word_to_isrc(logic [31:0] w);
    isrc_t s;
    s.rxf = w[BIT_RXF];
    s.txe = w[BIT_TXE];
    s.brk = w[BIT_BRK];
    s.tmo = w[BIT_TMO];
    return s;
  endfunction
endpackage

// File: rtl/uirq_fifo.sv
`timescale 1ns/1ps
module uirq_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uirq_src.sv
`timescale 1ns/1ps
module uirq_src
  import uirq_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [TW-1:0] rx_thr,
  input  logic [TW-1:0] tx_thr,
  input  logic          brk_evt,
  input  logic          tmo_evt,
  input  logic          clr_wr,
  input  isrc_t         clr_bits,
  input  isrc_t         ien,
  output isrc_t         raw,
  output isrc_t         masked,
  output logic          irq
);
  function automatic logic at_or_above(logic [CW-1:0] c, logic [TW-1:0] t);
    return c >= CW'(t);
  endfunction

  function automatic logic at_or_below(logic [CW-1:0] c, logic [TW-1:0] t);
    return c <= CW'(t);
  endfunction

  // Sticky flags: index 0 = break, 1 = timeout. Set wins over clear.
  logic [1:0] evt, clr_sel, flag;
  assign evt     = {tmo_evt, brk_evt};
  assign clr_sel = {clr_bits.tmo, clr_bits.brk};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[gi] <= 1'b0;
      else        flag[gi] <= evt[gi] | (flag[gi] & ~(clr_wr & clr_sel[gi]));
    end
  end

  always_comb begin
    raw.rxf = at_or_above(rx_cnt, rx_thr);
    raw.txe = at_or_below(tx_cnt, tx_thr);
    raw.brk = flag[0];
    raw.tmo = flag[1];
    masked  = raw & ien;
  end

  assign irq = |masked;
endmodule

// File: rtl/uart_irq_regbank.sv
`timescale 1ns/1ps
module uart_irq_regbank
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DW     = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_data,
  output logic              tx_avail,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_data,
  input  logic              brk_evt,
  input  logic              tmo_evt,
  output logic              dma_en,
  output logic              loop_en,
  output logic [7:0]        line_ctl,
  output logic [20:0]       baud_div,
  output logic              irq
);
  // Count fields are 8 bits wide in the status word: DEPTH <= 255.
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int TW      = $clog2(DEPTH);
  localparam int THR_DEF = DEPTH / 2;

  function automatic logic at(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // Named bus events
  logic tx_wr, rx_rd, clr_wr;
  assign tx_wr  = bus_wr & at(bus_addr, OFS_TXD);
  assign rx_rd  = bus_rd & at(bus_addr, OFS_RXD);
  assign clr_wr = bus_wr & at(bus_addr, OFS_ICLR);

  // Registers
  isrc_t         ien_q;
  logic [7:0]    lcr_q;
  logic [31:0]   ctl1_q;
  logic [TW-1:0] rx_thr_q, tx_thr_q;
  logic [15:0]   div_lo_q;
  logic [4:0]    div_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      lcr_q    <= '0;
      ctl1_q   <= '0;
      rx_thr_q <= TW'(THR_DEF);
      tx_thr_q <= TW'(THR_DEF);
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else if (bus_wr) begin
      if (at(bus_addr, OFS_IEN))  ien_q  <= word_to_isrc(bus_wdata);
      if (at(bus_addr, OFS_LCR))  lcr_q  <= bus_wdata[7:0];
      if (at(bus_addr, OFS_CTL1)) ctl1_q <= bus_wdata;
      if (at(bus_addr, OFS_CTL2)) begin
        rx_thr_q <= bus_wdata[TW-1:0];
        tx_thr_q <= bus_wdata[8 +: TW];
      end
      if (at(bus_addr, OFS_DIVL)) div_lo_q <= bus_wdata[15:0];
      if (at(bus_addr, OFS_DIVH)) div_hi_q <= bus_wdata[4:0];
    end
  end

  // FIFOs
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;

  uirq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .push_data(bus_wdata[DW-1:0]),
    .pop(tx_pop), .head(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  uirq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_data),
    .pop(rx_rd), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // Interrupt sources
  isrc_t src_raw, src_masked;

  uirq_src #(.CW(CW), .TW(TW)) u_src (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
    .brk_evt(brk_evt), .tmo_evt(tmo_evt),
    .clr_wr(clr_wr), .clr_bits(word_to_isrc(bus_wdata)),
    .ien(ien_q), .raw(src_raw), .masked(src_masked), .irq(irq)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (8'(bus_addr))
      OFS_RXD:  bus_rdata[DW-1:0] = rx_head;
      OFS_LST: begin
        bus_rdata[0]  = ~rx_empty;
        bus_rdata[7]  = src_raw.brk;
        bus_rdata[15] = ~tx_full;
      end
      OFS_FST: begin
        bus_rdata[CW-1:0]  = rx_cnt;
        bus_rdata[8 +: CW] = tx_cnt;
      end
      OFS_IEN:  bus_rdata = isrc_to_word(ien_q);
      OFS_LCR:  bus_rdata[7:0] = lcr_q;
      OFS_CTL1: bus_rdata = ctl1_q;
      OFS_CTL2: begin
        bus_rdata[TW-1:0] = rx_thr_q;
        bus_rdata[8 +: TW] = tx_thr_q;
      end
      OFS_DIVL: bus_rdata[15:0] = div_lo_q;
      OFS_DIVH: bus_rdata[4:0]  = div_hi_q;
      OFS_IMS:  bus_rdata = isrc_to_word(src_masked);
      default:  bus_rdata = '0;
    endcase
    if (ADDR_W > 8 && (bus_addr >> 8) != '0) bus_rdata = '0;
  end

  assign tx_avail = ~tx_empty;
  assign dma_en   = ctl1_q[15];
  assign loop_en  = ctl1_q[14];
  assign line_ctl = lcr_q;
  assign baud_div = {div_hi_q, div_lo_q};

  logic unused_ok;
  assign unused_ok = rx_full;
endmodule

// File: rtl/uirq_chk.sv
`timescale 1ns/1ps
module uirq_chk
  import uirq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic          rx_rd,
  input logic          rx_push,
  input logic          brk_evt,
  input logic          tmo_evt,
  input logic          clr_wr,
  input logic [31:0]   clr_word,
  input isrc_t         raw,
  input isrc_t         ien,
  input logic          irq
);
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH)); // R2
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && tx_wr && !tx_pop) |=> tx_cnt == CW'(DEPTH)); // R2
  AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rx_rd && !rx_push) |=> rx_cnt == '0); // R3
  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH) && rx_push && !rx_rd) |=> rx_cnt == CW'(DEPTH)); // R12
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> raw.brk); // R6
  AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> raw.tmo); // R6
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw.brk && !(clr_wr && clr_word[BIT_BRK])) |=> raw.brk); // R6
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw.tmo && !(clr_wr && clr_word[BIT_TMO])) |=> raw.tmo); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0)); // R8
endmodule

bind uart_irq_regbank uirq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_wr(tx_wr), .tx_pop(tx_pop), .rx_rd(rx_rd), .rx_push(rx_push),
  .brk_evt(brk_evt), .tmo_evt(tmo_evt),
  .clr_wr(clr_wr), .clr_word(bus_wdata),
  .raw(src_raw), .ien(ien_q), .irq(irq)
);

// File: tb/uart_irq_regbank_tb.sv
`timescale 1ns/1ps
module uart_irq_regbank_tb;
  localparam int DEPTH = 128;
  localparam logic [7:0] A_TXD = 8'h00, A_RXD = 8'h04, A_LST = 8'h08,
    A_FST = 8'h0C, A_IEN = 8'h10, A_CLR = 8'h14, A_LCR = 8'h18,
    A_CTL1 = 8'h1C, A_CTL2 = 8'h20, A_DIVL = 8'h24, A_DIVH = 8'h28,
    A_IMS = 8'h2C, A_NONE = 8'h3C;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0, brk_evt = 0, tmo_evt = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] tx_data, rx_data = 0, line_ctl;
  logic tx_avail, dma_en, loop_en, irq;
  logic [20:0] baud_div;

  always #4 clk = ~clk;

  uart_irq_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
    .rx_push(rx_push), .rx_data(rx_data), .brk_evt(brk_evt),
    .tmo_evt(tmo_evt), .dma_en(dma_en), .loop_en(loop_en),
    .line_ctl(line_ctl), .baud_div(baud_div), .irq(irq));

  int checks = 0, errors = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [31:0] m_ien = 0;
  int m_rthr = 64, m_tthr = 64;
  logic m_brk = 0, m_tmo = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_raw();
    logic [31:0] r = 0;
    r[0]  = rx_q.size() >= m_rthr;
    r[1]  = tx_q.size() <= m_tthr;
    r[7]  = m_brk;
    r[13] = m_tmo;
    return r;
  endfunction

  function automatic logic [31:0] exp_lst();
    logic [31:0] r = 0;
    r[0]  = rx_q.size() != 0;
    r[7]  = m_brk;
    r[15] = tx_q.size() < DEPTH;
    return r;
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_wr = 0; bus_rd = 0; bus_addr = a;
    #0.2 v = bus_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v, ms;
    rd(A_FST, v);
    chk("R4 fifo status", v, {16'h0, 8'(tx_q.size()), 8'(rx_q.size())});
    ms = exp_raw() & m_ien;
    rd(A_IMS, v);
    chk("R7 masked status", v, ms);
    chk("R8 irq", {31'b0, irq}, {31'b0, ms != 0});
    rd(A_LST, v);
    chk("R11 line status", v, exp_lst());
    chk("R2 tx_avail", {31'b0, tx_avail}, {31'b0, tx_q.size() != 0});
  endtask

  // One clock: drive at negedge, check same-cycle data, update model at posedge.
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic rd_s, input logic tp, input logic rp,
                      input logic [7:0] rd_b, input logic bp, input logic op);
    bit txpop_ok, txpush_ok, rxpop_ok, rxpush_ok;
    bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_rd = rd_s;
    tx_pop = tp; rx_push = rp; rx_data = rd_b; brk_evt = bp; tmo_evt = op;
    #0.2;
    if (rd_s && a == A_RXD)
      chk("R3 rx read data", bus_rdata, rx_q.size() != 0 ? {24'h0, rx_q[0]} : 32'h0);
    if (tp && tx_q.size() != 0)
      chk("R2 tx order", {24'h0, tx_data}, {24'h0, tx_q[0]});
    @(posedge clk);
    txpop_ok  = tp && tx_q.size() > 0;
    txpush_ok = wr && a == A_TXD && tx_q.size() < DEPTH;
    rxpop_ok  = rd_s && a == A_RXD && rx_q.size() > 0;
    rxpush_ok = rp && rx_q.size() < DEPTH;
    if (txpop_ok)  void'(tx_q.pop_front());
    if (txpush_ok) tx_q.push_back(wd[7:0]);
    if (rxpop_ok)  void'(rx_q.pop_front());
    if (rxpush_ok) rx_q.push_back(rd_b);
    if (wr && a == A_IEN) m_ien = wd & 32'h0000_2083;
    if (wr && a == A_CTL2) begin m_rthr = int'(wd[6:0]); m_tthr = int'(wd[14:8]); end
    m_brk = bp | (m_brk & ~(wr && a == A_CLR && wd[7]));
    m_tmo = op | (m_tmo & ~(wr && a == A_CLR && wd[13]));
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0; brk_evt = 0; tmo_evt = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 8'h0, 0, 0);
  endtask
  task automatic eng(input logic tp, input logic rp, input logic [7:0] b,
                     input logic bp, input logic op);
    step(0, A_NONE, 0, 0, tp, rp, b, bp, op);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_all();
    rd(A_CTL2, v); chk("R1 ctl2 default", v, 32'h0000_4040);
    rd(A_IEN, v);  chk("R1 enable default", v, 32'h0);
    rd(A_CTL1, v); chk("R1 ctl1 default", v, 32'h0);
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    chk("R1 baud_div", {11'h0, baud_div}, 32'h0);

    // R9 control word
    wr_reg(A_CTL1, 32'hA5A5_C000);
    chk("R9 dma_en", {31'b0, dma_en}, 32'h1);
    chk("R9 loop_en", {31'b0, loop_en}, 32'h1);
    rd(A_CTL1, v); chk("R9 readback", v, 32'hA5A5_C000);
    wr_reg(A_CTL1, 32'h0000_4000);
    chk("R9 dma_en off", {31'b0, dma_en}, 32'h0);
    chk("R9 loop_en on", {31'b0, loop_en}, 32'h1);

    // R10 line control and divider
    wr_reg(A_LCR, 32'hFFFF_FF3C);
    wr_reg(A_DIVL, 32'hFFFF_1234);
    wr_reg(A_DIVH, 32'hFFFF_FFFF);
    chk("R10 line_ctl", {24'h0, line_ctl}, 32'h3C);
    chk("R10 baud_div", {11'h0, baud_div}, {11'h0, 5'h1F, 16'h1234});
    rd(A_DIVH, v); chk("R10 divh readback", v, 32'h1F);
    rd(A_LCR, v);  chk("R10 lcr readback", v, 32'h3C);

    // R5 watermark boundaries, R7/R8 masking
    wr_reg(A_CTL2, 32'h0000_0203);
    rd(A_CTL2, v); chk("R5 ctl2 readback", v, 32'h0000_0203);
    wr_reg(A_IEN, 32'h0000_0003);
    check_all();
    for (int i = 0; i < 3; i++) begin wr_reg(A_TXD, 32'h10 + i); check_all(); end
    rd(A_IMS, v); chk("R5 tx above watermark", v & 32'h2, 32'h0);
    for (int i = 0; i < 3; i++) begin eng(0, 1, 8'hA0 + 8'(i), 0, 0); check_all(); end
    rd(A_IMS, v); chk("R5 rx at watermark", v & 32'h1, 32'h1);
    wr_reg(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, v); chk("R7 enable keeps four bits", v, 32'h0000_2083);

    // R6 sticky flags
    eng(0, 0, 0, 1, 0); check_all();
    wr_reg(A_CLR, 32'h0); check_all();
    rd(A_LST, v); chk("R6 zero write keeps break", v & 32'h80, 32'h80);
    step(1, A_CLR, 32'h80, 0, 0, 0, 0, 1, 0); check_all();
    rd(A_IMS, v); chk("R6 set wins over clear", v & 32'h80, 32'h80);
    wr_reg(A_CLR, 32'h80); check_all();
    eng(0, 0, 0, 0, 1); check_all();
    rd(A_IMS, v); chk("R6 timeout set", v & 32'h2000, 32'h2000);
    wr_reg(A_CLR, 32'hFFFF_FFFF); check_all();
    rd(A_IMS, v); chk("R6 clear all", v & 32'h2080, 32'h0);

    // Drain, then R2 full transmit FIFO
    while (rx_q.size() != 0) step(0, A_RXD, 0, 1, 0, 0, 0, 0, 0);
    while (tx_q.size() != 0) eng(1, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 1; i++) wr_reg(A_TXD, 32'(i * 7 + 3));
    rd(A_FST, v); chk("R2 tx full count", v, 32'h0000_8000);
    check_all();
    while (tx_q.size() != 0) eng(1, 0, 0, 0, 0);
    check_all();

    // R12 full receive FIFO, R3 drain and empty read
    for (int i = 0; i < DEPTH + 1; i++) eng(0, 1, 8'(i * 5 + 1), 0, 0);
    rd(A_FST, v); chk("R12 rx full count", v, 32'h0000_0080);
    check_all();
    while (rx_q.size() != 0) step(0, A_RXD, 0, 1, 0, 0, 0, 0, 0);
    step(0, A_RXD, 0, 1, 0, 0, 0, 0, 0);
    rd(A_FST, v); chk("R3 empty read keeps count", v, 32'h0);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 10);
      logic tp = ($urandom % 3) == 0;
      logic rp = ($urandom % 3) == 0;
      logic bp = ($urandom % 20) == 0;
      logic op = ($urandom % 20) == 0;
      logic [31:0] d = $urandom;
      case (r)
        0, 1, 2: step(1, A_TXD, d, 0, tp, rp, 8'($urandom), bp, op);
        3, 4:    step(0, A_RXD, 0, 1, tp, rp, 8'($urandom), bp, op);
        5:       step(1, A_IEN, d, 0, tp, rp, 8'($urandom), bp, op);
        6:       step(1, A_CLR, d, 0, tp, rp, 8'($urandom), bp, op);
        7:       step(1, A_CTL2, d & 32'h7F7F, 0, tp, rp, 8'($urandom), bp, op);
        default: step(0, A_NONE, 0, 0, tp, rp, 8'($urandom), bp, op);
      endcase
      check_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule